// File: doc/BRIEF.md
# Width-Switchable Static Memory with Byte Lanes

This block models a static memory array that can be read and written either as words of two byte lanes or as a flat byte memory of twice the depth. A static width-select input chooses the organisation. Both views use the same storage, so a byte written in byte mode can be read back as half of a word in word mode, and the other way round. The model is synchronous: writes take effect on a rising clock edge, and read data is registered, so it appears on the cycle after the edge that accepted the read.

The device is active only when its active-low enable is low and its active-high enable is high. An active-low output enable gates read data. An active-low write enable starts a write. In word mode, two active-low lane enables control each byte lane. The bus is modelled as a data vector plus one drive bit per lane. A lane that is not driven stands for a high-impedance lane and reads as zero. When the block is deselected it raises a sleep indication, and it ignores reads and writes. The array depth is a parameter, and the address width follows from it.

Top module: `dualwidth_sram`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `rdata` is zero, `rdata_drive` is 2'b00 and `asleep` is 1.
- R2: The block is selected only when `sel_n`=0 and `sel_hi`=1. On any other combination, writes leave the array unchanged, and on the following cycle `rdata_drive`=2'b00 and `asleep`=1. A selected cycle gives `asleep`=0 on the following cycle.
- R3: In word mode (`mode_wide`=1), a selected edge with `we_n`=0 writes `wdata[7:0]` when `lo_lane_n`=0 and `wdata[15:8]` when `hi_lane_n`=0. A lane whose enable is high keeps its stored value.
- R4: In word mode, the word index is `addr[AW-2:0]`, and the top address bit is ignored. A selected edge with `we_n`=1 and `oe_n`=0 gives, on the next cycle, `rdata_drive[0]`=~`lo_lane_n` and `rdata_drive[1]`=~`hi_lane_n`. Each driven lane carries its stored byte.
- R5: In byte mode (`mode_wide`=0), the word index is `addr[AW-1:1]`. `addr[0]`=0 selects bits 7:0 of the stored word and `addr[0]`=1 selects bits 15:8. A write stores `wdata[7:0]` into the selected half and ignores the lane enables.
- R6: In byte mode, a read returns the selected byte on `rdata[7:0]` with `rdata_drive`=2'b01 and `rdata[15:8]`=0, whatever the lane enables are.
- R7: Write has priority. A selected edge with `we_n`=0 and `oe_n`=0 performs the write and gives `rdata_drive`=2'b00 on the next cycle.
- R8: A selected edge with `we_n`=1 and `oe_n`=1 drives nothing on the next cycle and changes no stored data.
- R9: Any lane whose `rdata_drive` bit is 0 reads as zero on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| mode_wide | input | 1 | 1 = word organisation, 0 = byte organisation |
| sel_n | input | 1 | Active-low device enable |
| sel_hi | input | 1 | Active-high device enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| hi_lane_n | input | 1 | Active-low upper lane enable (word mode only) |
| lo_lane_n | input | 1 | Active-low lower lane enable (word mode only) |
| addr | input | AW | Address; AW = log2(DEPTH)+1 |
| wdata | input | 2*LANE_W | Write data |
| rdata | output | 2*LANE_W | Registered read data; undriven lanes are zero |
| rdata_drive | output | 2 | Per-lane drive indication (bit 0 = lower lane) |
| asleep | output | 1 | Deselected / power-down indication |

## Verification
The hardest state to reach is a location whose two halves were last written through different views. For example, one half is set by a byte-mode write to an odd address, and the other half by a word-mode write with only one lane enabled. The stimulus first fills every word in word mode. It then overwrites single halves through byte mode, with both lane enables held inactive, and through partial word writes. Finally it reads each touched location back through both views, so that a swapped half, a wrong index shift or a lane enable that leaks into byte mode shows up as a mismatch against the reference array.

// File: rtl/sram_pkg.sv
package sram_pkg;
   localparam int unsigned SRAM_LANES = 2;

   typedef logic [SRAM_LANES-1:0] lane_vec_t;

   // one-hot lane for a byte-mode half select
   function automatic lane_vec_t half_to_lane(input logic upper);
      return upper ? lane_vec_t'(2'b10) : lane_vec_t'(2'b01);
   endfunction
endpackage

// File: rtl/sram_select_decode.sv
module sram_select_decode (
   input  logic sel_n,
   input  logic sel_hi,
   input  logic oe_n,
   input  logic we_n,
   output logic chip_on,
   output logic do_write,
   output logic do_read
);
   always_comb begin
      chip_on  = !sel_n && sel_hi;
      do_write = chip_on && !we_n;
      // write wins over output enable
      do_read  = chip_on && we_n && !oe_n;
   end
endmodule

// File: rtl/sram_lane_route.sv
module sram_lane_route
   import sram_pkg::*;
#(
   parameter int unsigned IW     = 8,
   parameter int unsigned LANE_W = 8
) (
   input  logic                           mode_wide,
   input  logic [IW:0]                    addr,
   input  logic [SRAM_LANES*LANE_W-1:0]   wdata,
   input  logic                           hi_lane_n,
   input  logic                           lo_lane_n,
   input  logic                           do_write,
   output logic [IW-1:0]                  word_idx,
   output lane_vec_t                      lane_we,
   output logic [SRAM_LANES*LANE_W-1:0]   lane_wd,
   output lane_vec_t                      rd_mask,
   output logic                           byte_hi
);
   lane_vec_t lane_mask;

   always_comb begin
      byte_hi = addr[0];
      if (mode_wide) begin
         word_idx  = addr[IW-1:0];
         lane_mask = {~hi_lane_n, ~lo_lane_n};
         lane_wd   = wdata;
         rd_mask   = lane_mask;
      end else begin
         word_idx  = addr[IW:1];
         lane_mask = half_to_lane(addr[0]);
         lane_wd   = {SRAM_LANES{wdata[LANE_W-1:0]}};
         rd_mask   = lane_vec_t'(2'b01);
      end
      lane_we = do_write ? lane_mask : '0;
   end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned IW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IW-1:0]     idx,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] rd
);
   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wd;
   end

   assign rd = mem[idx];
endmodule

// File: rtl/dualwidth_sram.sv
module dualwidth_sram
   import sram_pkg::*;
#(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned IW    = $clog2(DEPTH),
   localparam int unsigned AW    = IW + 1,
   localparam int unsigned DW    = SRAM_LANES * LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_wide,
   input  logic          sel_n,
   input  logic          sel_hi,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          hi_lane_n,
   input  logic          lo_lane_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [1:0]    rdata_drive,
   output logic          asleep
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be positive");
   end

   logic            chip_on, do_write, do_read;
   logic [IW-1:0]   word_idx;
   lane_vec_t       lane_we, rd_mask;
   logic [DW-1:0]   lane_wd;
   logic            byte_hi;
   logic [LANE_W-1:0] bank_rd [SRAM_LANES];
   logic [DW-1:0]   rd_next;
   lane_vec_t       drv_next;

   sram_select_decode u_sel (
      .sel_n    (sel_n),
      .sel_hi   (sel_hi),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .chip_on  (chip_on),
      .do_write (do_write),
      .do_read  (do_read)
   );

   sram_lane_route #(.IW(IW), .LANE_W(LANE_W)) u_route (
      .mode_wide (mode_wide),
      .addr      (addr),
      .wdata     (wdata),
      .hi_lane_n (hi_lane_n),
      .lo_lane_n (lo_lane_n),
      .do_write  (do_write),
      .word_idx  (word_idx),
      .lane_we   (lane_we),
      .lane_wd   (lane_wd),
      .rd_mask   (rd_mask),
      .byte_hi   (byte_hi)
   );

   for (genvar l = 0; l < SRAM_LANES; l++) begin : g_lane
      sram_lane_bank #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_bank (
         .clk (clk),
         .we  (lane_we[l]),
         .idx (word_idx),
         .wd  (lane_wd[l*LANE_W +: LANE_W]),
         .rd  (bank_rd[l])
      );
   end

   always_comb begin
      rd_next  = '0;
      drv_next = do_read ? rd_mask : '0;
      if (do_read) begin
         if (mode_wide) begin
            for (int l = 0; l < SRAM_LANES; l++) begin
               if (rd_mask[l]) rd_next[l*LANE_W +: LANE_W] = bank_rd[l];
            end
         end else begin
            rd_next[LANE_W-1:0] = byte_hi ? bank_rd[1] : bank_rd[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata       <= '0;
         rdata_drive <= '0;
         asleep      <= 1'b1;
      end else begin
         rdata       <= rd_next;
         rdata_drive <= drv_next;
         asleep      <= !chip_on;
      end
   end
endmodule

// File: rtl/sram_checker.sv
module sram_checker #(
   parameter int unsigned LANE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mode_wide,
   input logic                sel_n,
   input logic                sel_hi,
   input logic                oe_n,
   input logic                we_n,
   input logic                hi_lane_n,
   input logic                lo_lane_n,
   input logic [2*LANE_W-1:0] rdata,
   input logic [1:0]          rdata_drive,
   input logic                asleep
);
   logic sel;
   assign sel = !sel_n && sel_hi;

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (asleep && rdata_drive == 2'b00 && rdata == '0));

   p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (asleep && rdata_drive == 2'b00));

   p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel |=> !asleep);

   p_wide_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wide && sel && !oe_n && we_n) |=>
         rdata_drive == {~$past(hi_lane_n), ~$past(lo_lane_n)});

   p_byte_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wide && sel && !oe_n && we_n) |=> rdata_drive == 2'b01);

   p_write_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !we_n) |=> rdata_drive == 2'b00);

   p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> rdata_drive == 2'b00);

   p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_drive[0] |-> rdata[LANE_W-1:0] == '0);

   p_high_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_drive[1] |-> rdata[2*LANE_W-1:LANE_W] == '0);
endmodule

bind dualwidth_sram sram_checker #(.LANE_W(LANE_W)) u_sram_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_wide   (mode_wide),
   .sel_n       (sel_n),
   .sel_hi      (sel_hi),
   .oe_n        (oe_n),
   .we_n        (we_n),
   .hi_lane_n   (hi_lane_n),
   .lo_lane_n   (lo_lane_n),
   .rdata       (rdata),
   .rdata_drive (rdata_drive),
   .asleep      (asleep)
);

// File: tb/test_dualwidth_sram.sv
module test_dualwidth_sram;
   localparam int unsigned DEPTH  = 256;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned IW     = $clog2(DEPTH);
   localparam int unsigned AW     = IW + 1;
   localparam int unsigned DW     = 2 * LANE_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wide = 1'b1;
   logic          sel_n = 1'b1, sel_hi = 1'b0, oe_n = 1'b1, we_n = 1'b1;
   logic          hi_lane_n = 1'b1, lo_lane_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [1:0]    rdata_drive;
   logic          asleep;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [DW-1:0] d;
      logic [1:0]    v;
      logic          slp;
      string         tag;
   } exp_t;

   exp_t          q[$];
   logic [DW-1:0] ref_mem [DEPTH];

   always #5 clk = ~clk;

   dualwidth_sram #(.DEPTH(DEPTH), .LANE_W(LANE_W)) i_dualwidth_sram (
      .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .sel_n(sel_n),
      .sel_hi(sel_hi), .oe_n(oe_n), .we_n(we_n), .hi_lane_n(hi_lane_n),
      .lo_lane_n(lo_lane_n), .addr(addr), .wdata(wdata), .rdata(rdata),
      .rdata_drive(rdata_drive), .asleep(asleep)
   );

   task automatic check(input string tag, input logic [DW-1:0] d, input logic [1:0] v,
                        input logic slp, input logic [DW-1:0] ed, input logic [1:0] ev,
                        input logic eslp);
      total++;
      if (d !== ed || v !== ev || slp !== eslp) begin
         bad++;
         $display("FAIL %s: data=%h drive=%b asleep=%b expected data=%h drive=%b asleep=%b",
                  tag, d, v, slp, ed, ev, eslp);
      end
   endtask

   // monitor: samples 2 ns after each rising edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, rdata, rdata_drive, asleep, e.d, e.v, e.slp);
      end
   end

   // driver: one access per cycle, expected outcome pushed to the scoreboard
   task automatic op(input logic m, input logic sn, input logic sh, input logic on,
                     input logic wn, input logic hn, input logic ln,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      exp_t e;
      logic sel;
      logic [IW-1:0] idx;
      @(negedge clk);
      mode_wide = m; sel_n = sn; sel_hi = sh; oe_n = on; we_n = wn;
      hi_lane_n = hn; lo_lane_n = ln; addr = a; wdata = d;
      sel   = !sn && sh;
      e.d   = '0;
      e.v   = 2'b00;
      e.slp = !sel;
      e.tag = tag;
      idx   = m ? a[IW-1:0] : a[AW-1:1];
      if (sel && !wn) begin
         if (m) begin
            if (!ln) ref_mem[idx][LANE_W-1:0]    = d[LANE_W-1:0];
            if (!hn) ref_mem[idx][DW-1:LANE_W]   = d[DW-1:LANE_W];
         end else if (a[0]) begin
            ref_mem[idx][DW-1:LANE_W] = d[LANE_W-1:0];
         end else begin
            ref_mem[idx][LANE_W-1:0]  = d[LANE_W-1:0];
         end
      end else if (sel && !on) begin
         if (m) begin
            if (!ln) begin e.v[0] = 1'b1; e.d[LANE_W-1:0]  = ref_mem[idx][LANE_W-1:0];  end
            if (!hn) begin e.v[1] = 1'b1; e.d[DW-1:LANE_W] = ref_mem[idx][DW-1:LANE_W]; end
         end else begin
            e.v = 2'b01;
            e.d[LANE_W-1:0] = a[0] ? ref_mem[idx][DW-1:LANE_W] : ref_mem[idx][LANE_W-1:0];
         end
      end
      q.push_back(e);
   endtask

   task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic hn, input logic ln, input string tag);
      op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, hn, ln, a, d, tag);
   endtask
   task automatic rd_word(input logic [AW-1:0] a, input logic hn, input logic ln, input string tag);
      op(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, hn, ln, a, '0, tag);
   endtask
   task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, a, d, tag);
   endtask
   task automatic rd_byte(input logic [AW-1:0] a, input string tag);
      op(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, a, 16'hFFFF, tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, in reset and on the first cycle after release
      repeat (3) @(posedge clk);
      #2;
      check("R1", rdata, rdata_drive, asleep, '0, 2'b00, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check("R1", rdata, rdata_drive, asleep, '0, 2'b00, 1'b1);

      // R3: fill every word through both lanes
      for (int i = 0; i < DEPTH; i++)
         wr_word(AW'(i), {8'(i) ^ 8'h3C, ~8'(i)}, 1'b0, 1'b0, "R3");
      // R4: read everything back as full words
      for (int i = 0; i < DEPTH; i++)
         rd_word(AW'(i), 1'b0, 1'b0, "R4");

      // R3: partial lane writes keep the disabled lane
      wr_word(AW'(5), 16'hBEEF, 1'b1, 1'b0, "R3");
      wr_word(AW'(6), 16'hCAFE, 1'b0, 1'b1, "R3");
      wr_word(AW'(7), 16'h1234, 1'b1, 1'b1, "R3");
      rd_word(AW'(5), 1'b0, 1'b0, "R3");
      rd_word(AW'(6), 1'b0, 1'b0, "R3");
      rd_word(AW'(7), 1'b0, 1'b0, "R3");

      // R4 and R9: single-lane and no-lane reads
      rd_word(AW'(6), 1'b1, 1'b0, "R9");
      rd_word(AW'(6), 1'b0, 1'b1, "R9");
      rd_word(AW'(6), 1'b1, 1'b1, "R9");

      // R4: top address bit ignored in word mode
      wr_word(AW'(DEPTH + 9), 16'h600D, 1'b0, 1'b0, "R4");
      rd_word(AW'(9), 1'b0, 1'b0, "R4");
      rd_word(AW'(DEPTH + 9), 1'b0, 1'b0, "R4");

      // R5: byte writes land in the correct half, lane enables ignored
      wr_byte(AW'(2*12 + 1), 16'hFF5A, "R5");
      wr_byte(AW'(2*13),     16'h00C3, "R5");
      rd_word(AW'(12), 1'b0, 1'b0, "R5");
      rd_word(AW'(13), 1'b0, 1'b0, "R5");
      // R6: byte reads, both halves
      rd_byte(AW'(2*12 + 1), "R6");
      rd_byte(AW'(2*12),     "R6");
      rd_byte(AW'(2*13),     "R6");
      rd_byte(AW'(2*200 + 1), "R6");

      // R5: aliasing across a range
      for (int i = 32; i < 48; i++)
         wr_byte(AW'(2*i + (i % 2)), DW'(8'(i * 7 + 1)), "R5");
      for (int i = 32; i < 48; i++)
         rd_word(AW'(i), 1'b0, 1'b0, "R5");

      // R2: deselected accesses are ignored
      op(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, AW'(20), 16'hDEAD, "R2");
      op(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(21), 16'hDEAD, "R2");
      op(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(22), 16'hDEAD, "R2");
      op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, AW'(2*23), 16'h00EE, "R2");
      op(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, AW'(20), '0, "R2");
      op(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(20), '0, "R2");
      for (int i = 20; i < 24; i++)
         rd_word(AW'(i), 1'b0, 1'b0, "R2");

      // R8: output enable off drives nothing
      op(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, AW'(30), 16'h7777, "R8");
      op(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, AW'(61), 16'h7777, "R8");
      rd_word(AW'(30), 1'b0, 1'b0, "R8");

      // R7: write wins over output enable
      op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, AW'(40), 16'hA1B2, "R7");
      op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, AW'(2*41 + 1), 16'h0099, "R7");
      rd_word(AW'(40), 1'b0, 1'b0, "R7");
      rd_word(AW'(41), 1'b0, 1'b0, "R7");

      // idle, deselected
      op(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, "R2");
      wait (q.size() == 0);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule